// File: doc/BRIEF.md
# Control Register Side-Effect Unit

This unit holds a small set of processor control registers and turns each register write into the side-effect strobes that the rest of the core needs. Software-visible state lives in seven 64-bit registers, selected by a 3-bit index, and one index is left unsupported. A write compares the incoming value with the stored one through an XOR toggle mask. The bits that changed decide whether translation-buffer flush strobes fire, whether the long-mode-active flag in the extended-feature register follows the paging-enable bit, and whether the mode decoder is asked to recompute its state.

The unit has one write port and one combinational read port. The flush strobes go to the instruction-side and the data-side translation buffers. There are two kinds: a full flush, and a flush of non-global entries only. All strobes are registered one-cycle pulses that appear in the cycle after the write is sampled. The unit does not walk page tables or hold translation entries. It only raises the requests.

Top module: `ctlreg_fx_unit`

## Requirements
- R1: After reset the registers read as follows: index 0 (mode control) 0x60000010, index 5 (page attributes) 0x0007040600070406, index 6 (memory top) 0x4000000. Index 1 (table base), index 2 (feature control), index 3 (extended features) and index 4 (code segment attributes) read 0. All pulse outputs are 0.
- R2: Bit 4 of the mode-control register (index 0) always reads 1, whatever value was written to it.
- R3: A mode-control write that changes bit 31 (paging enable) while bit 8 (long enable) of the extended-feature register (index 3) is 1 copies the new bit 31 into bit 10 (long active) of index 3. When bit 8 is 0, index 3 is left unchanged.
- R4: A mode-control write that changes bit 31 raises itlb_full_o and dtlb_full_o. A mode-control write that leaves bit 31 unchanged raises neither.
- R5: Every write to index 1 (table base) raises itlb_ng_o and dtlb_ng_o, whatever value is written.
- R6: A write to index 2 (feature control) that changes bit 4, bit 5 or bit 7 raises itlb_full_o and dtlb_full_o. A write that changes only other bits raises neither.
- R7: Writes to index 0 and to index 4 raise mode_req_o. Writes to any other index do not.
- R8: A write to index 7 (unsupported) changes no register and raises wr_err_o.
- R9: Every pulse output is high only in the single cycle after the write that causes it, and is 0 after a cycle with no write. rd_data_o shows the stored value of rd_idx_i in the same cycle, and reads 0 for index 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | 3 | Index of the register to write |
| wr_data_i | input | 64 | Write data |
| rd_idx_i | input | 3 | Index of the register to read |
| rd_data_o | output | 64 | Read data (combinational) |
| itlb_full_o | output | 1 | Full flush request, instruction side |
| dtlb_full_o | output | 1 | Full flush request, data side |
| itlb_ng_o | output | 1 | Non-global flush request, instruction side |
| dtlb_ng_o | output | 1 | Non-global flush request, data side |
| mode_req_o | output | 1 | Mode recompute request |
| wr_err_o | output | 1 | Write to an unsupported index |

## Verification
Mode-control writes are tried in three forms: with paging enable toggled on and off while long enable is set, with it toggled while long enable is clear, and with bit 31 held steady while other bits change. Together these separate the toggle-driven flush and long-active update from a level-driven one. Feature-control writes alternate between changing a flush-relevant bit and changing only a neutral bit, which shows that the flush is masked. Table-base writes are issued back to back with identical data, which shows that the non-global flush fires on every write and not only on a change. Writes to the plain registers, writes to the unsupported index and idle cycles confirm that no stray pulse or state change appears.

// File: rtl/cru_pkg.sv
package cru_pkg;
  localparam int DATA_W = 64;
  localparam int IDX_W  = 3;
  localparam int NREG   = 7;

  localparam int IX_MCTL   = 0;
  localparam int IX_TBASE  = 1;
  localparam int IX_FCTL   = 2;
  localparam int IX_XFEAT  = 3;
  localparam int IX_CSATTR = 4;
  localparam int IX_PATTR  = 5;
  localparam int IX_MEMTOP = 6;

  localparam int BIT_PG  = 31;
  localparam int BIT_FIX = 4;
  localparam int BIT_LME = 8;
  localparam int BIT_LMA = 10;

  typedef logic [DATA_W-1:0] word_t;

  localparam word_t FCTL_FLUSH_MASK = word_t'(64'hB0);

  function automatic word_t rst_val(int i);
    case (i)
      IX_MCTL:   return word_t'(64'h6000_0010);
      IX_PATTR:  return word_t'(64'h0007_0406_0007_0406);
      IX_MEMTOP: return word_t'(64'h0400_0000);
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/cru_regfile.sv
module cru_regfile
  import cru_pkg::*;
#(
  parameter int N = NREG,
  parameter int IW = IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IW-1:0]     widx_i,
  input  word_t             wdata_i,
  input  logic              lma_upd_i,
  input  logic              lma_val_i,
  output word_t [N-1:0]     regs_o
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    localparam word_t RV = rst_val(i);
    logic hit;
    assign hit = we_i && (widx_i == IW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_o[i] <= RV;
      end else if (hit) begin
        if (i == IX_MCTL) regs_o[i] <= wdata_i | (word_t'(1) << BIT_FIX);
        else              regs_o[i] <= wdata_i;
      end else if (i == IX_XFEAT && lma_upd_i) begin
        regs_o[i][BIT_LMA] <= lma_val_i;
      end
    end
  end
endmodule

// File: rtl/cru_effects.sv
module cru_effects
  import cru_pkg::*;
#(
  parameter int N = NREG,
  parameter int IW = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  word_t         wdata_i,
  input  logic          pg_old_i,
  input  logic          lme_i,
  input  word_t         fctl_q_i,
  output logic          lma_upd_o,
  output logic          lma_val_o,
  output logic          full_o,
  output logic          ng_o,
  output logic          mode_o,
  output logic          err_o
);
  logic w_mctl, w_tbase, w_fctl, w_cs, w_bad;
  logic pg_tog, fctl_tog;
  logic full_d, ng_d, mode_d, err_d;

  always_comb begin
    w_mctl  = we_i && widx_i == IW'(IX_MCTL);
    w_tbase = we_i && widx_i == IW'(IX_TBASE);
    w_fctl  = we_i && widx_i == IW'(IX_FCTL);
    w_cs    = we_i && widx_i == IW'(IX_CSATTR);
    w_bad   = we_i && (int'(widx_i) >= N);
    // toggle masks select the actions
    pg_tog   = pg_old_i ^ wdata_i[BIT_PG];
    fctl_tog = |((fctl_q_i ^ wdata_i) & FCTL_FLUSH_MASK);

    lma_upd_o = w_mctl && pg_tog && lme_i;
    lma_val_o = wdata_i[BIT_PG];
    full_d    = (w_mctl && pg_tog) || (w_fctl && fctl_tog);
    ng_d      = w_tbase;
    mode_d    = w_mctl || w_cs;
    err_d     = w_bad;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      ng_o   <= 1'b0;
      mode_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      full_o <= full_d;
      ng_o   <= ng_d;
      mode_o <= mode_d;
      err_o  <= err_d;
    end
  end
endmodule

// File: rtl/ctlreg_fx_unit.sv
module ctlreg_fx_unit
  import cru_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              itlb_full_o,
  output logic              dtlb_full_o,
  output logic              itlb_ng_o,
  output logic              dtlb_ng_o,
  output logic              mode_req_o,
  output logic              wr_err_o
);
  word_t [NREG-1:0] regs;
  logic lma_upd, lma_val, full, ng;

  cru_regfile #(.N(NREG), .IW(IDX_W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_en_i),
    .widx_i    (wr_idx_i),
    .wdata_i   (wr_data_i),
    .lma_upd_i (lma_upd),
    .lma_val_i (lma_val),
    .regs_o    (regs)
  );

  cru_effects #(.N(NREG), .IW(IDX_W)) u_fx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_en_i),
    .widx_i    (wr_idx_i),
    .wdata_i   (wr_data_i),
    .pg_old_i  (regs[IX_MCTL][BIT_PG]),
    .lme_i     (regs[IX_XFEAT][BIT_LME]),
    .fctl_q_i  (regs[IX_FCTL]),
    .lma_upd_o (lma_upd),
    .lma_val_o (lma_val),
    .full_o    (full),
    .ng_o      (ng),
    .mode_o    (mode_req_o),
    .err_o     (wr_err_o)
  );

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_idx_i == IDX_W'(i)) rd_data_o = regs[i];
  end

  assign itlb_full_o = full;
  assign dtlb_full_o = full;
  assign itlb_ng_o   = ng;
  assign dtlb_ng_o   = ng;
endmodule

// File: rtl/ctlreg_fx_unit_chk.sv
module ctlreg_fx_unit_chk
  import cru_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [IDX_W-1:0]  wr_idx_i,
  input logic [IDX_W-1:0]  rd_idx_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              itlb_full_o,
  input logic              dtlb_full_o,
  input logic              itlb_ng_o,
  input logic              dtlb_ng_o,
  input logic              mode_req_o,
  input logic              wr_err_o
);
  a_r2_fixed_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx_i == IDX_W'(IX_MCTL) |-> rd_data_o[BIT_FIX]);

  a_r5_ng_every_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_idx_i == IDX_W'(IX_TBASE) |=> itlb_ng_o && dtlb_ng_o);

  a_r7_mode_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_idx_i == IDX_W'(IX_MCTL) || wr_idx_i == IDX_W'(IX_CSATTR))
    |=> mode_req_o);

  a_r8_bad_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && int'(wr_idx_i) >= NREG |=> wr_err_o);

  a_r9_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !(itlb_full_o || itlb_ng_o || mode_req_o || wr_err_o));

  a_r9_bad_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rd_idx_i) >= NREG |-> rd_data_o == '0);

  a_r4_sides_paired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    itlb_full_o == dtlb_full_o && itlb_ng_o == dtlb_ng_o);
endmodule

bind ctlreg_fx_unit ctlreg_fx_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_idx_i    (wr_idx_i),
  .rd_idx_i    (rd_idx_i),
  .rd_data_o   (rd_data_o),
  .itlb_full_o (itlb_full_o),
  .dtlb_full_o (dtlb_full_o),
  .itlb_ng_o   (itlb_ng_o),
  .dtlb_ng_o   (dtlb_ng_o),
  .mode_req_o  (mode_req_o),
  .wr_err_o    (wr_err_o)
);

// File: tb/ctlreg_fx_unit_tb_top.sv
module ctlreg_fx_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_idx_i = '0;
  logic [63:0] wr_data_i = '0;
  logic [2:0]  rd_idx_i = '0;
  logic [63:0] rd_data_o;
  logic itlb_full_o, dtlb_full_o, itlb_ng_o, dtlb_ng_o, mode_req_o, wr_err_o;

  always #10 clk_i = ~clk_i;

  ctlreg_fx_unit dut_i (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] m [0:6];
  bit e_full, e_ng, e_mode, e_err;

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check_regs(string tag);
    for (int i = 0; i < 8; i++) begin
      rd_idx_i = 3'(i);
      #1;
      chk(tag, $sformatf("reg%0d", i), rd_data_o, (i < 7) ? m[i] : 64'h0);
    end
  endtask

  task automatic check_pulses(bit en, int idx);
    string ft;
    ft = !en ? "R9" : (idx == 2 ? "R6" : "R4");
    chk(ft, "itlb_full", 64'(itlb_full_o), 64'(e_full));
    chk(ft, "dtlb_full", 64'(dtlb_full_o), 64'(e_full));
    chk(en ? "R5" : "R9", "itlb_ng", 64'(itlb_ng_o), 64'(e_ng));
    chk(en ? "R5" : "R9", "dtlb_ng", 64'(dtlb_ng_o), 64'(e_ng));
    chk(en ? "R7" : "R9", "mode_req", 64'(mode_req_o), 64'(e_mode));
    chk(en ? "R8" : "R9", "wr_err", 64'(wr_err_o), 64'(e_err));
  endtask

  // reference model of one write
  task automatic model(bit en, int idx, logic [63:0] d);
    e_full = 0; e_ng = 0; e_mode = 0; e_err = 0;
    if (!en) return;
    case (idx)
      0: begin
        if (m[0][31] != d[31]) begin
          e_full = 1;
          if (m[3][8]) m[3][10] = d[31];
        end
        m[0] = d | 64'h10;
        e_mode = 1;
      end
      1: begin e_ng = 1; m[1] = d; end
      2: begin
        if (((m[2] ^ d) & 64'hB0) != 0) e_full = 1;
        m[2] = d;
      end
      4: begin e_mode = 1; m[4] = d; end
      7: e_err = 1;
      default: m[idx] = d;
    endcase
  endtask

  task automatic step(bit en, int idx, logic [63:0] d, string tag);
    wr_en_i = en; wr_idx_i = 3'(idx); wr_data_i = d;
    model(en, idx, d);
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check_pulses(en, idx);
    check_regs(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m[0] = 64'h6000_0010; m[1] = 0; m[2] = 0; m[3] = 0; m[4] = 0;
    m[5] = 64'h0007_0406_0007_0406; m[6] = 64'h0400_0000;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    e_full = 0; e_ng = 0; e_mode = 0; e_err = 0;
    check_pulses(1'b0, 0);          // R1 reset pulses
    check_regs("R1");

    step(1, 0, 64'h0, "R2");                  // bit 4 forced, PG unchanged
    step(1, 0, 64'h0000_0000_0000_0021, "R2");
    step(1, 1, 64'h1234_5000, "R5");
    step(1, 1, 64'h1234_5000, "R5");          // same data, flush again
    step(1, 2, 64'h20, "R6");                 // flush-relevant bit
    step(1, 2, 64'h21, "R6");                 // neutral bit only
    step(1, 2, 64'h01, "R6");
    step(1, 2, 64'h81, "R6");
    step(1, 3, 64'h100, "R3");                // long enable
    step(1, 0, 64'h8000_0001, "R3");          // PG on -> active set
    step(1, 0, 64'h8000_0031, "R4");          // PG steady
    step(1, 0, 64'h0000_0001, "R3");          // PG off -> active clear
    step(1, 3, 64'h0, "R3");
    step(1, 0, 64'h8000_0001, "R3");          // no long enable
    step(1, 4, 64'hABC, "R7");
    step(1, 5, 64'hDEAD_BEEF_0000_1111, "R7");
    step(1, 6, 64'h0800_0000, "R7");
    step(1, 7, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    step(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R9"); // idle
    step(0, 1, 64'h0, "R9");
    step(1, 0, 64'h0, "R4");
    step(0, 0, 64'h0, "R9");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule